// File: doc/BRIEF.md
# Serial Programming Command Port

This block sits behind a test access port and turns 15-bit scan words into programming actions for a non-volatile memory. Each word carries a 7-bit strobe code in its upper bits and an 8-bit argument in its lower bits. The word enters serially, least significant bit first, while the previous command's result leaves on the serial output.

The TAP controller supplies one-cycle strobes for capture, shift, update and run-idle. An update latches the shifted word as the pending command, but only while programming mode is enabled. One run-idle cycle then executes it. Executing a load strobe writes the mode, address or data registers. Executing any other strobe counts as a read and samples the memory's data byte and done flag into a result register. The next capture returns that register.

Top module: `prog_cmd_port`

## Requirements
- R1: After synchronous reset the mode, address, write data, strobe code, execute pulse and serial output are all zero.
- R2: A capture loads the result word into the scan register: bits 7:0 hold the last result byte, bit 9 holds the last done flag, and every other bit is 0. Shifting then presents that word on `tdo`, bit 0 first.
- R3: Each shift cycle moves `tdi` into bit 14 and moves the word one place toward bit 0. After 15 shifts, the first bit sent sits in bit 0. The strobe code is bits 14:8 and the argument is bits 7:0.
- R4: An update while `prog_en` is high latches the scan word: its strobe appears on `cmd_code` and the command becomes pending. Nothing executes until a run-idle cycle. `exec_pulse` goes high for one cycle, in the cycle after the run-idle cycle.
- R5: Executing strobe 0100011 copies the argument into `mode` (for example 0x10 for flash write, 0x02 for flash read, 0x00 for no operation).
- R6: Executing strobe 0000011 loads address bits 7:0, strobe 0000111 loads bits 15:8 and strobe 0001011 loads bits 23:16. Bits at or above `ADDR_W` are discarded.
- R7: Executing strobe 0010011 loads `wdata[7:0]` and strobe 0010111 loads `wdata[15:8]`.
- R8: While `prog_en` is low, an update changes neither the latched command nor any state, and no execute pulse follows.
- R9: Executing a strobe other than the six load strobes samples `mem_rdata` and `mem_done` into the result at the end of its `exec_pulse` cycle. Load strobes leave the result unchanged.
- R10: One update allows at most one execution. Further run-idle cycles without a new update produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Programming mode active |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| run_idle | input | 1 | Run-idle cycle strobe |
| tdi | input | 1 | Serial data in |
| mem_rdata | input | 8 | Byte returned by the memory |
| mem_done | input | 1 | Memory operation complete flag |
| tdo | output | 1 | Serial data out (bit 0 of scan register) |
| cmd_code | output | 7 | Strobe code of the latched command |
| mode | output | 8 | Selected operation mode |
| addr | output | ADDR_W | Implemented address bits |
| wdata | output | 16 | Write data word |
| exec_pulse | output | 1 | One-cycle execute strobe |

## Verification
Output bit k of a scan is read in shift cycle k. That is one cycle after the capture strobe and before any shift edge has moved the word. The monitor samples `tdo` 1 ns after each falling edge, while the shift strobe is high.

Register loads become visible one edge after the run-idle cycle, and `exec_pulse` is high in that same following cycle. The result is captured on the edge that ends the pulse. For that reason the driver waits three falling edges after the run-idle cycle before it checks `mode`, `addr` or `wdata`. Only after that wait does it start the scan whose output reveals the result.

// File: rtl/prog_cmd_pkg.sv
// Shared field widths and strobe codes for the programming command port.
package prog_cmd_pkg;
    localparam int STB_W    = 7;
    localparam int ARG_W    = 8;
    localparam int CMD_W    = STB_W + ARG_W;
    localparam int DONE_BIT = 9;
    localparam int FULL_ADR = 24;

    localparam logic [STB_W-1:0] STB_MODE  = 7'b0100011;
    localparam logic [STB_W-1:0] STB_ADR_X = 7'b0001011;
    localparam logic [STB_W-1:0] STB_ADR_H = 7'b0000111;
    localparam logic [STB_W-1:0] STB_ADR_L = 7'b0000011;
    localparam logic [STB_W-1:0] STB_DAT_L = 7'b0010011;
    localparam logic [STB_W-1:0] STB_DAT_H = 7'b0010111;

    // True for strobes that write state rather than read the memory.
    function automatic logic is_load(input logic [STB_W-1:0] s);
        return (s == STB_MODE)  || (s == STB_ADR_X) || (s == STB_ADR_H) ||
               (s == STB_ADR_L) || (s == STB_DAT_L) || (s == STB_DAT_H);
    endfunction
endpackage

// File: rtl/prog_cmd_shreg.sv
// Scan register: parallel capture of the result word, LSB-first shift.
// Assumes capture and shift strobes are one TAP cycle each; capture wins.
module prog_cmd_shreg #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_word,
    output logic [W-1:0] sr,
    output logic         tdo
);
    // Capture or shift the scan word.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (cap)   sr <= cap_word;
        else if (shift) sr <= {tdi, sr[W-1:1]};
    end

    assign tdo = sr[0];

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> sr == $past(cap_word));
    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !cap) |=> sr[W-1] == $past(tdi));
endmodule

// File: rtl/prog_cmd_exec.sv
// Command latch and executor: latches the scan word on update (when enabled),
// runs it on one run-idle cycle, and holds mode, address and write data.
// Assumes ADDR_W is at most 24.
module prog_cmd_exec
    import prog_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              upd,
    input  logic              run_idle,
    input  logic [CMD_W-1:0]  sr_in,
    output logic [STB_W-1:0]  cmd_code,
    output logic [ARG_W-1:0]  mode,
    output logic [ADDR_W-1:0] addr,
    output logic [15:0]       wdata,
    output logic              exec_pulse
);
    logic [CMD_W-1:0]    cmd_q;
    logic                pending;
    logic [FULL_ADR-1:0] adr_wide;
    logic [FULL_ADR-1:0] adr_next;
    logic [ARG_W-1:0]    arg;
    logic                go;

    assign cmd_code = cmd_q[CMD_W-1:ARG_W];
    assign arg      = cmd_q[ARG_W-1:0];
    assign go       = run_idle && pending;

    // Widen the address, splice the addressed byte in, then drop high bits.
    always_comb begin
        adr_wide = '0;
        adr_wide[ADDR_W-1:0] = addr;
        adr_next = adr_wide;
        case (cmd_code)
            STB_ADR_L: adr_next[7:0]   = arg;
            STB_ADR_H: adr_next[15:8]  = arg;
            STB_ADR_X: adr_next[23:16] = arg;
            default:   adr_next = adr_wide;
        endcase
    end

    // Latch the command on update and track whether it is still pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            pending <= 1'b0;
        end else if (upd && prog_en) begin
            cmd_q   <= sr_in;
            pending <= 1'b1;
        end else if (go) begin
            pending <= 1'b0;
        end
    end

    // Execute the pending command: pulse, then apply load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_pulse <= 1'b0;
            mode       <= '0;
            addr       <= '0;
            wdata      <= '0;
        end else begin
            exec_pulse <= go;
            if (go) begin
                addr <= adr_next[ADDR_W-1:0];
                if (cmd_code == STB_MODE)  mode        <= arg;
                if (cmd_code == STB_DAT_L) wdata[7:0]  <= arg;
                if (cmd_code == STB_DAT_H) wdata[15:8] <= arg;
            end
        end
    end

    assert_exec_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> $past(run_idle));
    assert_single_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |=> !exec_pulse);
    assert_ignore_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !prog_en) |=> $stable(cmd_code));
    assert_mode_idle_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_idle |=> $stable(mode));
endmodule

// File: rtl/prog_cmd_result.sv
// Result holder: samples memory byte and done flag when a read-type command
// executes and forms the word returned at the next capture.
module prog_cmd_result
    import prog_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_pulse,
    input  logic [STB_W-1:0] cmd_code,
    input  logic [ARG_W-1:0] mem_rdata,
    input  logic             mem_done,
    output logic [CMD_W-1:0] cap_word
);
    logic [ARG_W-1:0] res_byte;
    logic             res_done;
    logic             rd_exec;

    assign rd_exec = exec_pulse && !is_load(cmd_code);

    // Keep the last read result until another read executes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_byte <= '0;
            res_done <= 1'b0;
        end else if (rd_exec) begin
            res_byte <= mem_rdata;
            res_done <= mem_done;
        end
    end

    // Place the byte and done flag at their word positions.
    always_comb begin
        cap_word              = '0;
        cap_word[ARG_W-1:0]   = res_byte;
        cap_word[DONE_BIT]    = res_done;
    end

    assert_load_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_pulse && is_load(cmd_code)) |=> $stable(cap_word));
    assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_pulse |=> $stable(cap_word));
endmodule

// File: rtl/prog_cmd_port.sv
// Top of the serial programming command port: scan register, command
// executor and result holder. Assumes TAP strobes are mutually exclusive.
module prog_cmd_port
    import prog_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              cap_dr,
    input  logic              shift_dr,
    input  logic              upd_dr,
    input  logic              run_idle,
    input  logic              tdi,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_done,
    output logic              tdo,
    output logic [6:0]        cmd_code,
    output logic [7:0]        mode,
    output logic [ADDR_W-1:0] addr,
    output logic [15:0]       wdata,
    output logic              exec_pulse
);
    logic [CMD_W-1:0] sr;
    logic [CMD_W-1:0] cap_word;

    prog_cmd_shreg #(.W(CMD_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .cap(cap_dr), .shift(shift_dr), .tdi(tdi),
        .cap_word(cap_word), .sr(sr), .tdo(tdo)
    );

    prog_cmd_exec #(.ADDR_W(ADDR_W)) u_exec (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .upd(upd_dr),
        .run_idle(run_idle), .sr_in(sr), .cmd_code(cmd_code), .mode(mode),
        .addr(addr), .wdata(wdata), .exec_pulse(exec_pulse)
    );

    prog_cmd_result u_result (
        .clk(clk), .rst_n(rst_n), .exec_pulse(exec_pulse), .cmd_code(cmd_code),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .cap_word(cap_word)
    );
endmodule

// File: tb/test_prog_cmd_port.sv
// Scoreboard bench: the scan task pushes the expected serial output word,
// the monitor assembles the observed word and compares.
module test_prog_cmd_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0;
    logic        upd_dr = 1'b0, run_idle = 1'b0, tdi = 1'b0;
    logic [7:0]  mem_rdata;
    logic        mem_done = 1'b0;
    logic        tdo;
    logic [6:0]  cmd_code;
    logic [7:0]  mode;
    logic [16:0] addr;
    logic [15:0] wdata;
    logic        exec_pulse;

    int vectors = 0, errors = 0, exec_cnt = 0;
    bit finished = 1'b0;
    logic [14:0] exp_q[$];
    string       req_q[$];

    always #4 clk = ~clk;

    // Memory stub: byte derived from the address.
    assign mem_rdata = addr[7:0] ^ 8'h5A;

    prog_cmd_port i_prog_cmd_port (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .run_idle(run_idle), .tdi(tdi),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .tdo(tdo),
        .cmd_code(cmd_code), .mode(mode), .addr(addr), .wdata(wdata),
        .exec_pulse(exec_pulse)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    // Monitor: collect tdo bits during shift, count execute pulses.
    initial begin
        logic [14:0] got;
        int n;
        n = 0;
        got = '0;
        forever begin
            @(negedge clk);
            #1;
            if (exec_pulse) exec_cnt++;
            if (shift_dr) begin
                got[n] = tdo;
                n++;
                if (n == 15) begin
                    n = 0;
                    if (exp_q.size() == 0) chk("scoreboard", 32'(got), 32'hDEAD);
                    else chk(req_q.pop_front(), 32'(got), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic scan(input logic [6:0] stb, input logic [7:0] arg,
                        input logic [14:0] exp_out, input string r, input int idles);
        logic [14:0] cmd;
        cmd = {stb, arg};
        exp_q.push_back(exp_out);
        req_q.push_back(r);
        @(negedge clk); cap_dr = 1'b1;
        @(negedge clk); cap_dr = 1'b0;
        for (int i = 0; i < 15; i++) begin
            shift_dr = 1'b1; tdi = cmd[i];
            @(negedge clk);
        end
        shift_dr = 1'b0; upd_dr = 1'b1;
        @(negedge clk); upd_dr = 1'b0;
        if (idles > 0) begin
            run_idle = 1'b1;
            repeat (idles) @(negedge clk);
            run_idle = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 tdo", 32'(tdo), 0);
        chk("R1 mode", 32'(mode), 0);
        chk("R1 addr", 32'(addr), 0);
        chk("R1 wdata", 32'(wdata), 0);
        chk("R1 cmd_code", 32'(cmd_code), 0);
        chk("R1 exec", 32'(exec_pulse), 0);

        // R8: disabled mode ignores the update
        scan(7'b0100011, 8'h02, 15'h0000, "R2 reset result", 1);
        chk("R8 mode", 32'(mode), 0);
        chk("R8 cmd_code", 32'(cmd_code), 0);
        chk("R8 exec count", 32'(exec_cnt), 0);

        prog_en = 1'b1;
        scan(7'b0100011, 8'h10, 15'h0000, "R2", 1);
        chk("R5 mode", 32'(mode), 32'h10);
        chk("R4 cmd_code", 32'(cmd_code), 32'h23);
        chk("R4 exec count", 32'(exec_cnt), 1);

        scan(7'b0001011, 8'hFF, 15'h0000, "R2", 1);
        scan(7'b0000111, 8'hAB, 15'h0000, "R2", 1);
        scan(7'b0000011, 8'hCD, 15'h0000, "R3", 1);
        chk("R6 addr trimmed", 32'(addr), 32'h1ABCD);

        scan(7'b0010011, 8'h34, 15'h0000, "R3", 1);
        scan(7'b0010111, 8'h12, 15'h0000, "R3", 1);
        chk("R7 wdata", 32'(wdata), 32'h1234);

        // R9: read with done high, byte = 0xCD ^ 0x5A = 0x97
        mem_done = 1'b1;
        scan(7'b0110010, 8'h00, 15'h0000, "R9 before read", 1);
        scan(7'b0100011, 8'h02, 15'h0297, "R9 read result", 1);
        chk("R5 mode flash read", 32'(mode), 32'h02);
        scan(7'b0000011, 8'h00, 15'h0297, "R9 load keeps result", 1);
        chk("R6 addr low", 32'(addr), 32'h1AB00);

        // R9: poll with done low, byte = 0x00 ^ 0x5A
        mem_done = 1'b0;
        scan(7'b0110011, 8'h00, 15'h0297, "R9 before poll", 1);
        chk("R4 exec count", 32'(exec_cnt), 10);

        // R4: update without run-idle does not execute
        scan(7'b0100011, 8'h11, 15'h005A, "R9 poll done flag", 0);
        chk("R4 no exec mode", 32'(mode), 32'h02);
        chk("R4 no exec count", 32'(exec_cnt), 10);

        // R10: two run-idle cycles give one execution
        run_idle = 1'b1;
        repeat (2) @(negedge clk);
        run_idle = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 exec count", 32'(exec_cnt), 11);
        chk("R10 mode", 32'(mode), 32'h11);

        chk("scoreboard empty", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule